// File: doc/BRIEF.md
# ECC Syndrome DIMM Pin Locator

This block takes a corrected-error report and names the memory module and the connector pin that carried the failing bit. A report has three parts: a signed syndrome code, the physical address of the access, and the id of the bank that decoded that address. Two loadable lookup tables locate a single-bit error. The first is a packed module map with four 2-bit fields per byte. The second is a pin map with one byte per bit position of a 64-byte line. A multi-bit error cannot be narrowed to one module, so the block reports the whole group of four modules. A code outside the legal range gives an unknown result.

Each table is held twice. A symmetric flag chooses which copy is used for lookups. Tables and flag are written one entry per cycle through a load port, normally while the block is idle after boot. Each request is accepted with a valid/ready handshake. A fixed two cycles later the block raises a one-cycle done pulse, which carries the result flags, the module index, a module mask and the pin number.

Top module: `ecc_pin_locator`

## Requirements
- R1: While reset is applied and after it is released, `done` is low and `req_ready` is high.
- R2: A request accepted on a clock edge (valid and ready both high) produces `done` high for exactly one cycle, following the second rising edge after acceptance.
- R3: `req_ready` is low for the cycle after an acceptance, and a request held during that cycle is not taken.
- R4: A syndrome code below -1 or above 144 gives `unknown`=1, `multi`=0, `mod_idx`=0, `mod_mask`=0 and `pin`=0.
- R5: Code -1 gives `multi`=1, `pin`=0, `mod_idx` = first module, and `mod_mask` = 4'b1111 shifted left by the first module. The first module is (bank id bit 0) × 4.
- R6: Codes 0..127 are remapped by adding 16. Codes 128..143 are remapped by subtracting 137. Code 144 is remapped by subtracting 143.
- R7: The line position is (3 − q) × 144 + remapped code, where q = address bits [5:4]. A negative line position gives the R4 unknown result.
- R8: Let the reversed position be 575 − line position. The module map byte used is the one at the reversed position divided by 4. Its select bit sits at bit 2 × (3 − (reversed position mod 4)). `mod_idx` = first module + select, and `mod_mask` is one-hot at `mod_idx`.
- R9: For a single-bit code, `pin` is the pin map byte at the line position.
- R10: The symmetric flag resets to 1. When it is 1, lookups use copy 0; when it is 0, they use copy 1.
- R11: Loads take effect when `ld_en` is high. `ld_sel`=0 writes module map byte `ld_addr` of copy `ld_copy`. `ld_sel`=1 writes pin map byte `ld_addr` of that copy. `ld_sel`=2 sets the symmetric flag from `ld_data[0]`. `ld_sel`=3 does nothing, and so does a module map address ≥144 or a pin map address ≥576.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Table load strobe |
| ld_sel | input | 2 | Load target: 0 module map, 1 pin map, 2 symmetric flag |
| ld_copy | input | 1 | Table copy written |
| ld_addr | input | LD_AW | Entry index within the copy |
| ld_data | input | 8 | Entry value |
| req_valid | input | 1 | Error report present |
| req_ready | output | 1 | Block can take a report |
| req_syn | input | SYN_W | Signed syndrome code |
| req_addr | input | ADDR_W | Physical address of the failing access |
| req_bank | input | BANK_W | Id of the bank that decoded the address |
| done | output | 1 | One-cycle result strobe |
| unknown | output | 1 | Location cannot be determined |
| multi | output | 1 | Multi-bit error, whole group reported |
| mod_idx | output | 3 | Module index (first of group when multi) |
| mod_mask | output | 8 | Modules implicated |
| pin | output | 8 | Connector pin of the failing bit |

## Verification
An error in the remap or the line-position arithmetic shows up as a different pin byte on the very done pulse of the request. An error in the reversed-position split shows up instead as a wrong module select. Both are visible two cycles after acceptance. A stuck or miswritten table copy, or a lost symmetric flag, only shows once a lookup touches that entry. For this reason the tables are filled with a pattern that differs between copies and between neighbouring bytes, and the lookups sweep all four quadwords and both groups. A broken handshake shows as a missing, doubled or early done pulse within three cycles.

// File: rtl/ecc_pin_locator.sv
module ecc_pin_locator #(
  parameter int ADDR_W  = 40,
  parameter int SYN_W   = 10,
  parameter int BANK_W  = 6,
  parameter int QW_BITS = 144,
  parameter int LD_AW   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [1:0]        ld_sel,
  input  logic              ld_copy,
  input  logic [LD_AW-1:0]  ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SYN_W-1:0]  req_syn,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_bank,
  output logic              done,
  output logic              unknown,
  output logic              multi,
  output logic [2:0]        mod_idx,
  output logic [7:0]        mod_mask,
  output logic [7:0]        pin
);
  localparam int QWORDS    = 4;
  localparam int LINE_BITS = QW_BITS * QWORDS;
  localparam int MAP_N     = LINE_BITS / 4;
  localparam int LAST_BIT  = LINE_BITS - 1;
  localparam int MAX_SYN   = QW_BITS;
  localparam int MM_AW     = $clog2(2 * MAP_N);
  localparam int PM_AW     = $clog2(2 * LINE_BITS);

  logic [7:0] mmap [2*MAP_N];
  logic [7:0] pmap [2*LINE_BITS];

  logic sym_r, s1_v, s1_unk, s1_mul, s1_grp;
  logic [1:0] s1_sub;
  logic [7:0] mm_q, pm_q;
  logic acc, unk_c, mul_c, hit, cp, sel;
  logic [2:0] first, idx_c;
  logic [MM_AW-1:0] mm_ra;
  logic [PM_AW-1:0] pm_ra;
  int syn_i, rc_i, pos_i, rev_i;

  logic unused_bits;
  assign unused_bits = ^{req_addr[ADDR_W-1:6], req_addr[3:0], req_bank[BANK_W-1:1]};

  assign req_ready = !s1_v;
  assign acc       = req_valid && req_ready;
  assign cp        = !sym_r;

  always_comb begin
    syn_i = int'($signed(req_syn));
    if (syn_i < QW_BITS - 16)     rc_i = syn_i + 16;
    else if (syn_i < QW_BITS)     rc_i = syn_i - (QW_BITS - 7);
    else if (syn_i < QW_BITS + 3) rc_i = syn_i - (QW_BITS - 1);
    else                          rc_i = syn_i - (QW_BITS + 3);
    pos_i = (QWORDS - 1 - int'(req_addr[5:4])) * QW_BITS + rc_i;
    rev_i = LAST_BIT - pos_i;
    mul_c = (syn_i == -1);
    unk_c = (syn_i < -1) || (syn_i > MAX_SYN) || (syn_i >= 0 && pos_i < 0);
    hit   = !unk_c && !mul_c;
    mm_ra = hit ? MM_AW'(int'(cp) * MAP_N + rev_i / 4) : '0;
    pm_ra = hit ? PM_AW'(int'(cp) * LINE_BITS + pos_i) : '0;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_sel == 2'd0 && int'(ld_addr) < MAP_N)
      mmap[MM_AW'(int'(ld_copy) * MAP_N + int'(ld_addr))] <= ld_data;
    if (ld_en && ld_sel == 2'd1 && int'(ld_addr) < LINE_BITS)
      pmap[PM_AW'(int'(ld_copy) * LINE_BITS + int'(ld_addr))] <= ld_data;
    if (acc) begin
      mm_q <= mmap[mm_ra];
      pm_q <= pmap[pm_ra];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_r  <= 1'b1;
      s1_v   <= 1'b0;
      s1_unk <= 1'b0;
      s1_mul <= 1'b0;
      s1_grp <= 1'b0;
      s1_sub <= 2'd0;
    end else begin
      if (ld_en && ld_sel == 2'd2) sym_r <= ld_data[0];
      s1_v <= acc;
      if (acc) begin
        s1_unk <= unk_c;
        s1_mul <= mul_c;
        s1_grp <= req_bank[0];
        s1_sub <= rev_i[1:0];
      end
    end
  end

  assign first = {s1_grp, 2'b00};
  assign sel   = mm_q[{~s1_sub, 1'b0}];
  assign idx_c = first + {2'b00, sel};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      unknown  <= 1'b0;
      multi    <= 1'b0;
      mod_idx  <= 3'd0;
      mod_mask <= 8'd0;
      pin      <= 8'd0;
    end else begin
      done <= s1_v;
      if (s1_v) begin
        unknown <= s1_unk;
        multi   <= s1_mul && !s1_unk;
        if (s1_unk) begin
          mod_idx  <= 3'd0;
          mod_mask <= 8'd0;
          pin      <= 8'd0;
        end else if (s1_mul) begin
          mod_idx  <= first;
          mod_mask <= 8'h0F << first;
          pin      <= 8'd0;
        end else begin
          mod_idx  <= idx_c;
          mod_mask <= 8'h01 << idx_c;
          pin      <= pm_q;
        end
      end
    end
  end
endmodule

// File: rtl/ecc_pin_locator_chk.sv
module ecc_pin_locator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       unknown,
  input logic       multi,
  input logic [2:0] mod_idx,
  input logic [7:0] mod_mask,
  input logic [7:0] pin
);
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R3
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ##2 done); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_UNKNOWN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unknown) |-> (mod_mask == 8'd0 && !multi && pin == 8'd0)); // R4
  AST_MULTI_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && multi) |-> ($countones(mod_mask) == 4 && mod_idx[1:0] == 2'd0 && mod_mask[mod_idx])); // R5
  AST_SINGLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !unknown && !multi) |-> ($countones(mod_mask) == 1 && mod_mask[mod_idx])); // R8
endmodule

bind ecc_pin_locator ecc_pin_locator_chk u_chk (.*);

// File: tb/ecc_pin_locator_tb.sv
`timescale 1ns/1ps
module ecc_pin_locator_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0;
  logic [1:0] ld_sel = 2'd0;
  logic ld_copy = 1'b0;
  logic [9:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [9:0] req_syn = '0;
  logic [39:0] req_addr = '0;
  logic [5:0] req_bank = '0;
  logic done, unknown, multi;
  logic [2:0] mod_idx;
  logic [7:0] mod_mask, pin;

  int checks = 0;
  int errors = 0;
  bit [7:0] mm [2][144];
  bit [7:0] pm [2][576];
  bit sym = 1'b1;

  always #10 clk = ~clk;

  ecc_pin_locator u_dut (.*);

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] s, input logic c, input int a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = s; ld_copy = c; ld_addr = 10'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic void model(int syn, logic [39:0] a, logic [5:0] b,
                                output bit eu, output bit em, output int ei,
                                output int emask, output int ep);
    int first, rc, pos, rev, cp;
    bit [7:0] e;
    first = b[0] ? 4 : 0;
    cp = sym ? 0 : 1;
    eu = 0; em = 0; ei = 0; emask = 0; ep = 0;
    if (syn < -1 || syn > 144) begin eu = 1; return; end
    if (syn == -1) begin em = 1; ei = first; emask = 15 << first; return; end
    if (syn < 128) rc = syn + 16;
    else if (syn < 144) rc = syn - 137;
    else rc = syn - 143;
    pos = (3 - int'(a[5:4])) * 144 + rc;
    if (pos < 0) begin eu = 1; return; end
    rev = 575 - pos;
    e = mm[cp][rev / 4];
    ei = first + int'(e[2 * (3 - rev % 4)]);
    emask = 1 << ei;
    ep = pm[cp][pos];
  endfunction

  task automatic lookup(int syn, logic [39:0] a, logic [5:0] b, string rq);
    bit eu, em;
    int ei, emask, ep;
    model(syn, a, b, eu, em, ei, emask, ep);
    @(negedge clk);
    req_valid = 1'b1; req_syn = 10'(syn); req_addr = a; req_bank = b;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3", "ready low after accept", int'(req_ready), 0);
    chk("R2", "done not early", int'(done), 0);
    @(negedge clk);
    chk("R2", "done after two edges", int'(done), 1);
    chk(rq, "unknown", int'(unknown), int'(eu));
    chk(rq, "multi", int'(multi), int'(em));
    chk(rq, "mod_idx", int'(mod_idx), ei);
    chk(rq, "mod_mask", int'(mod_mask), emask);
    chk(rq, "pin", int'(pin), ep);
    @(negedge clk);
    chk("R2", "done single cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done after reset", int'(done), 0);
    chk("R1", "ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_fill();
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 144; i++) begin
        mm[c][i] = 8'((i * 37 + c * 91 + 5) & 255);
        load(2'd0, c[0], i, mm[c][i]);
      end
      for (int j = 0; j < 576; j++) begin
        pm[c][j] = 8'((j * 7 + c * 50 + 3) & 255);
        load(2'd1, c[0], j, pm[c][j]);
      end
    end
  endtask

  task automatic t_unknown();
    lookup(-2, 40'h0, 6'd0, "R4");
    lookup(145, 40'h10, 6'd1, "R4");
    lookup(300, 40'h20, 6'd0, "R4");
    lookup(128, 40'h30, 6'd0, "R7");
    lookup(136, 40'h30, 6'd1, "R7");
  endtask

  task automatic t_multi();
    lookup(-1, 40'h0, 6'd0, "R5");
    lookup(-1, 40'h30, 6'd1, "R5");
    lookup(-1, 40'h1234, 6'd7, "R5");
  endtask

  task automatic t_single();
    lookup(0, 40'h0, 6'd0, "R6");
    lookup(127, 40'h10, 6'd1, "R6");
    lookup(128, 40'h20, 6'd0, "R6");
    lookup(143, 40'h30, 6'd1, "R6");
    lookup(144, 40'h30, 6'd0, "R6");
    lookup(137, 40'h30, 6'd0, "R9");
    for (int k = 0; k < 40; k++)
      lookup((k * 29) % 145, 40'(k * 16 + 64 * k), 6'(k), "R8");
  endtask

  task automatic t_copy_select();
    load(2'd2, 1'b0, 0, 8'h00);
    sym = 1'b0;
    for (int k = 0; k < 20; k++)
      lookup((k * 31 + 3) % 145, 40'(k * 16), 6'(k + 1), "R10");
  endtask

  task automatic t_ignored_loads();
    load(2'd0, 1'b0, 144, ~mm[1][0]);
    load(2'd1, 1'b0, 576, ~pm[1][0]);
    load(2'd3, 1'b1, 0, 8'hA5);
    lookup(127, 40'h0, 6'd0, "R11");
    lookup(124, 40'h0, 6'd1, "R11");
    lookup(137, 40'h30, 6'd0, "R11");
    load(2'd2, 1'b0, 0, 8'h01);
    sym = 1'b1;
    lookup(127, 40'h0, 6'd0, "R10");
  endtask

  task automatic t_holdoff();
    @(negedge clk);
    req_valid = 1'b1; req_syn = 10'h3FF; req_bank = 6'd0;
    @(negedge clk);
    chk("R3", "ready low while busy", int'(req_ready), 0);
    @(negedge clk);
    chk("R2", "first done", int'(done), 1);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R3", "held request not taken", int'(done), 0);
    @(negedge clk);
    chk("R3", "no late done", int'(done), 0);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_unknown();
    t_multi();
    t_single();
    t_copy_select();
    t_ignored_loads();
    t_holdoff();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule